// File: doc/BRIEF.md
# Audio Control Register Write Port (Two-Wire Serial Slave)

This block is the write-only serial control port of a two-channel audio volume and input-selector chip. A fast system clock samples the bus clock and data lines. Both lines go through a synchronizer and a stability filter, so that spikes far shorter than one bus bit are rejected. The block then follows the standard two-wire protocol. It detects START, repeated START and STOP. It answers a fixed 7-bit device address with an acknowledge, and it pulls the data line low through an open-drain pull-down only during acknowledge bits.

After the address, the first byte sets a register pointer. Every later data byte writes the register at the pointer and then moves the pointer on. The pointer counts through three registers and wraps from the last one back to zero. Two registers hold the channel A and channel B volume codes, and the third holds the input-selector code. A write is decoded at once into a gain-step code and a mute flag per channel, and into a one-hot input-select vector. Codes outside the defined range leave the decoded outputs as they were.

Top module: `audio_ctl_i2c`

## Requirements
- R1: A write header (device address 1000001 in the first seven bits, sent MSB first, then R/W=0) is acknowledged: sda_pull is high from the SCL fall after the 8th bit until the SCL fall after the 9th bit.
- R2: A header with any other address is not acknowledged. The block then ignores the bus until the next START, so later bytes are neither acknowledged nor stored.
- R3: A header with the correct address and R/W=1 is not acknowledged, and the block never drives data back.
- R4: The byte after an acknowledged header loads the register pointer. Each data byte after that is acknowledged, written to the register at the pointer, and then advances the pointer in the order 0, 1, 2, 0.
- R5: A write to register 0 (channel A) or register 1 (channel B) with a low nibble of 0 to 8 sets that channel's gain_*_step to the code and clears its mute. Step 0 is +12 dB, and each step is 3 dB lower, down to step 8 at -12 dB. Bits 7:4 are ignored.
- R6: A volume code of 9 sets that channel's mute and leaves its gain step unchanged.
- R7: Volume codes 10 to 15 leave that channel's gain step and mute unchanged.
- R8: A write to register 2 with bits 2:0 equal to n (0 to 5) sets src_sel to a one-hot value with only bit n high; bit 0 is input 1. Bits 7:3 are ignored. Exactly one bit of src_sel is high at all times.
- R9: Selector codes 6 and 7 leave src_sel unchanged.
- R10: A repeated START at any point returns the block to address reception with the bit count cleared and the stored outputs kept.
- R11: A pulse on SCL or SDA that lasts fewer than FILT_CYC system clocks has no effect on the protocol.
- R12: After reset both gain steps are 4 (0 dB), both mutes are 0, src_sel is 000001 and sda_pull is 0.
- R13: A pointer byte of 3 or more is acknowledged. The data bytes that follow it are acknowledged but not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | High drives the data line low (open drain) |
| gain_a_step | output | 4 | Channel A gain step, 0 = +12 dB, 8 = -12 dB |
| mute_a | output | 1 | Channel A mute |
| gain_b_step | output | 4 | Channel B gain step |
| mute_b | output | 1 | Channel B mute |
| src_sel | output | 6 | One-hot input select, bit 0 = input 1 |

## Verification
A bus edge reaches the protocol logic 2 + FILT_CYC system clocks after it appears at a pin. A decoded output changes two clocks after the filtered SCL rise of the 8th bit of a data byte, and sda_pull changes one clock after a filtered SCL fall. The bench holds each SCL phase for at least 20 system clocks, which is far longer than these delays. It samples the acknowledge in the middle of the high phase of the 9th clock. It pushes the expected output state into the scoreboard 20 clocks after STOP, when every write of the transaction has settled, and the monitor compares on the next falling clock edge.

// File: rtl/actl_pkg.sv
// Package: shared constants and types for the audio control write port.
// Assumes two volume channels followed by one selector register.
package actl_pkg;
    localparam int NCH       = 2;
    localparam int VOL_W     = 4;
    localparam int MAX_STEP  = 8;
    localparam int MUTE_CODE = 9;
    localparam int RST_STEP  = 4;
    localparam int NSRC      = 6;
    localparam int SEL_W     = 3;
    localparam int NREG      = NCH + 1;
    localparam int PTR_W     = $clog2(NREG);
    localparam logic [6:0] DEV_ADDR = 7'b1000001;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_PTR, ST_DATA, ST_ACK, ST_SKIP
    } eng_st_t;
endpackage

// File: rtl/line_filter.sv
// Module: line_filter
// Synchronizes one bus line with two flops, then changes its output only after
// the synchronized input has disagreed with it for FILT_CYC clocks in a row.
// Assumes the line idles high (the reset value).
module line_filter #(
    parameter int FILT_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

    logic          sync1, sync2;
    logic [CW-1:0] cnt;

    // Two-flop synchronizer against metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= line_in;
            sync2 <= sync1;
        end
    end

    // Stability counter: flip the output once the input has held long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            line_out <= 1'b1;
        end else if (sync2 == line_out) begin
            cnt <= '0;
        end else if (cnt == CW'(FILT_CYC - 1)) begin
            cnt      <= '0;
            line_out <= sync2;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R11: the output only moves to a value the synchronized input already had.
    a_r11_flip_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        (line_out != $past(line_out)) |-> ($past(sync2) == line_out));
endmodule

// File: rtl/wr_engine.sv
// Module: wr_engine
// Bit-level protocol for the write-only slave working on filtered lines.
// It detects START and STOP, receives bytes MSB first and acknowledges them.
// It keeps the register pointer and issues one write strobe per stored byte.
// Assumes scl_f and sda_f are already clean and synchronous to clk.
module wr_engine
    import actl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_f,
    input  logic             sda_f,
    output logic             sda_pull,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [VOL_W-1:0] wr_data
);
    eng_st_t          state, ack_next;
    logic             scl_q, sda_q;
    logic [2:0]       bit_cnt;
    logic [6:0]       shreg;
    logic [PTR_W-1:0] ptr;
    logic             ptr_valid;
    logic             start_c, stop_c, rise, fall;
    logic [7:0]       byte_w;

    // Bus event decode from the current and previous filtered samples.
    always_comb begin
        start_c = scl_q & scl_f & sda_q & ~sda_f;
        stop_c  = scl_q & scl_f & ~sda_q & sda_f;
        rise    = ~scl_q & scl_f;
        fall    = scl_q & ~scl_f;
        byte_w  = {shreg, sda_f};
    end

    // Protocol state machine, byte receiver, pointer and acknowledge driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ack_next  <= ST_IDLE;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            bit_cnt   <= '0;
            shreg     <= '0;
            ptr       <= '0;
            ptr_valid <= 1'b0;
            sda_pull  <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            scl_q <= scl_f;
            sda_q <= sda_f;
            if (start_c) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (stop_c) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_DATA: begin
                        if (rise) begin
                            shreg   <= byte_w[6:0];
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 3'd7) begin
                                state    <= ST_ACK;
                                ack_next <= ST_DATA;
                                if (state == ST_ADDR) begin
                                    if (byte_w[7:1] == DEV_ADDR && !byte_w[0])
                                        ack_next <= ST_PTR;
                                    else
                                        state <= ST_SKIP;
                                end else if (state == ST_PTR) begin
                                    ptr_valid <= (int'(byte_w) < NREG);
                                    ptr       <= byte_w[PTR_W-1:0];
                                end else if (ptr_valid) begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= byte_w[VOL_W-1:0];
                                    ptr     <= (ptr == PTR_W'(NREG - 1)) ? '0 : ptr + 1'b1;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (fall) begin
                            if (!sda_pull) begin
                                sda_pull <= 1'b1;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ack_next;
                                bit_cnt  <= '0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: the data line is only pulled during an acknowledge slot.
    a_r1_pull_only_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> (state == ST_ACK));
    // R10: any START lands in address reception with a cleared bit count.
    a_r10_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (state == ST_ADDR && bit_cnt == 3'd0 && !sda_pull));
    // R3: a read header never leads to an acknowledge.
    a_r3_read_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && rise && bit_cnt == 3'd7 && sda_f && !start_c && !stop_c)
        |=> (state == ST_SKIP));
    // R2: while ignoring the bus, nothing is written.
    a_r2_skip_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !wr_en);
endmodule

// File: rtl/ctl_regs.sv
// Module: ctl_regs
// Holds the decoded control outputs. Each write updates them directly:
// volume codes become a gain step plus mute, and selector codes become a one-hot.
// Out-of-range codes keep the previous output. Assumes one write per strobe.
module ctl_regs
    import actl_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [PTR_W-1:0]          wr_addr,
    input  logic [VOL_W-1:0]          wr_data,
    output logic [NCH-1:0][VOL_W-1:0] gain_step,
    output logic [NCH-1:0]            mute,
    output logic [NSRC-1:0]           src_sel
);
    localparam logic [NSRC-1:0] SEL_ONE = NSRC'(1);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        // Volume decode for one channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gain_step[ch] <= VOL_W'(RST_STEP);
                mute[ch]      <= 1'b0;
            end else if (wr_en && wr_addr == PTR_W'(ch)) begin
                if (int'(wr_data) <= MAX_STEP) begin
                    gain_step[ch] <= wr_data;
                    mute[ch]      <= 1'b0;
                end else if (int'(wr_data) == MUTE_CODE) begin
                    mute[ch] <= 1'b1;
                end
            end
        end

        // R6: mute code sets mute and keeps the step.
        a_r6_mute_code: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == PTR_W'(ch) && int'(wr_data) == MUTE_CODE)
            |=> (mute[ch] && $stable(gain_step[ch])));
        // R7: undefined volume codes change nothing.
        a_r7_bad_vol_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == PTR_W'(ch) && int'(wr_data) > MUTE_CODE)
            |=> ($stable(gain_step[ch]) && $stable(mute[ch])));
    end

    // Input selector decode into a one-hot vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel <= SEL_ONE;
        end else if (wr_en && wr_addr == PTR_W'(NCH)) begin
            if (int'(wr_data[SEL_W-1:0]) < NSRC)
                src_sel <= SEL_ONE << wr_data[SEL_W-1:0];
        end
    end

    // R8: exactly one input is selected at all times.
    a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_sel) == 1);
    // R9: undefined selector codes keep the current selection.
    a_r9_bad_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == PTR_W'(NCH) && int'(wr_data[SEL_W-1:0]) >= NSRC)
        |=> $stable(src_sel));
endmodule

// File: rtl/audio_ctl_i2c.sv
// Module: audio_ctl_i2c (top)
// Write-only two-wire control port of a two-channel volume / selector chip:
// line filters, then the protocol engine, then the decoded control registers.
// Assumes clk is fast enough that FILT_CYC clocks span the spike width to reject.
module audio_ctl_i2c
    import actl_pkg::*;
#(
    parameter int FILT_CYC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_pull,
    output logic [VOL_W-1:0] gain_a_step,
    output logic             mute_a,
    output logic [VOL_W-1:0] gain_b_step,
    output logic             mute_b,
    output logic [NSRC-1:0]  src_sel
);
    logic [1:0]                raw_lines, filt_lines;
    logic                      wr_en;
    logic [PTR_W-1:0]          wr_addr;
    logic [VOL_W-1:0]          wr_data;
    logic [NCH-1:0][VOL_W-1:0] gain_step;
    logic [NCH-1:0]            mute;

    assign raw_lines = {scl_in, sda_in};

    for (genvar i = 0; i < 2; i++) begin : g_flt
        line_filter #(.FILT_CYC(FILT_CYC)) u_flt (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (raw_lines[i]),
            .line_out (filt_lines[i])
        );
    end

    wr_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt_lines[1]),
        .sda_f    (filt_lines[0]),
        .sda_pull (sda_pull),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    ctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .gain_step (gain_step),
        .mute      (mute),
        .src_sel   (src_sel)
    );

    assign gain_a_step = gain_step[0];
    assign gain_b_step = gain_step[1];
    assign mute_a      = mute[0];
    assign mute_b      = mute[1];
endmodule

// File: tb/audio_ctl_i2c_tb_top.sv
module audio_ctl_i2c_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       bus_sda;
    logic       sda_pull;
    logic [3:0] gain_a_step, gain_b_step;
    logic       mute_a, mute_b;
    logic [5:0] src_sel;

    assign bus_sda = m_sda & ~sda_pull;

    audio_ctl_i2c dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (m_scl),
        .sda_in      (bus_sda),
        .sda_pull    (sda_pull),
        .gain_a_step (gain_a_step),
        .mute_a      (mute_a),
        .gain_b_step (gain_b_step),
        .mute_b      (mute_b),
        .src_sel     (src_sel)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [3:0] ga;
        logic       ma;
        logic [3:0] gb;
        logic       mb;
        logic [5:0] sel;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side of the scoreboard: queue the expected output state.
    task automatic expect_state(input logic [3:0] ga, input logic ma, input logic [3:0] gb,
                                input logic mb, input logic [5:0] sel, input string req);
        exp_t e;
        wt(20);
        e.ga = ga; e.ma = ma; e.gb = gb; e.mb = mb; e.sel = sel; e.req = req;
        exp_q.push_back(e);
        wt(3);
    endtask

    // Monitor: pop each expected item and compare against the outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if ({gain_a_step, mute_a, gain_b_step, mute_b, src_sel} !==
                    {e.ga, e.ma, e.gb, e.mb, e.sel}) begin
                    n_fail++;
                    $display("FAIL %s: outputs ga=%0d ma=%0b gb=%0d mb=%0b sel=%b, expected ga=%0d ma=%0b gb=%0d mb=%0b sel=%b",
                             e.req, gain_a_step, mute_a, gain_b_step, mute_b, src_sel,
                             e.ga, e.ma, e.gb, e.mb, e.sel);
                end
            end
        end
    end

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wt(Q);
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_rstart();
        wt(Q / 2); m_sda = 1'b1; wt(Q / 2);
        m_scl = 1'b1; wt(Q);
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        wt(Q / 2); m_sda = 1'b0; wt(Q / 2);
        m_scl = 1'b1; wt(Q);
        m_sda = 1'b1; wt(Q);
    endtask

    // Send one byte MSB first, optionally with short spikes, then check the ack.
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req,
                             input bit glitch);
        bit got;
        for (int i = 7; i >= 0; i--) begin
            wt(Q / 4); m_sda = b[i];
            if (glitch && i == 7) begin
                m_scl = 1'b1; wt(3); m_scl = 1'b0;
            end
            wt(Q / 4);
            m_scl = 1'b1; wt(Q / 2);
            if (glitch && i == 6) begin
                m_sda = ~m_sda; wt(3); m_sda = b[i];
            end
            wt(Q / 2);
            m_scl = 1'b0;
        end
        wt(Q / 2); m_sda = 1'b1; wt(Q / 2);
        m_scl = 1'b1; wt(Q / 2);
        got = ~bus_sda;
        wt(Q / 2);
        m_scl = 1'b0;
        n_chk++;
        if (got !== exp_ack) begin
            n_fail++;
            $display("FAIL %s: ack for byte %h was %0b, expected %0b", req, b, got, exp_ack);
        end
    endtask

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        // R12: reset state
        n_chk++;
        if (sda_pull !== 1'b0) begin
            n_fail++;
            $display("FAIL R12: sda_pull %0b expected 0", sda_pull);
        end
        expect_state(4'd4, 1'b0, 4'd4, 1'b0, 6'b000001, "R12");

        // R1 R4 R5 R8: writes from pointer 0, then the pointer wraps to 0
        bus_start();
        send_byte(8'h82, 1'b1, "R1", 1'b0);
        send_byte(8'h00, 1'b1, "R4", 1'b0);
        send_byte(8'hF2, 1'b1, "R5", 1'b0);
        send_byte(8'h07, 1'b1, "R5", 1'b0);
        send_byte(8'h05, 1'b1, "R8", 1'b0);
        send_byte(8'h01, 1'b1, "R4", 1'b0);
        bus_stop();
        expect_state(4'd1, 1'b0, 4'd7, 1'b0, 6'b100000, "R4");

        // R6 R8 R7: mute on B, selector with upper bits set, bad code on A
        bus_start();
        send_byte(8'h82, 1'b1, "R1", 1'b0);
        send_byte(8'h01, 1'b1, "R4", 1'b0);
        send_byte(8'h09, 1'b1, "R6", 1'b0);
        send_byte(8'h0C, 1'b1, "R8", 1'b0);
        send_byte(8'h0B, 1'b1, "R7", 1'b0);
        bus_stop();
        expect_state(4'd1, 1'b0, 4'd7, 1'b1, 6'b010000, "R6");

        // R9: selector code 6 holds, then the wrap writes A
        bus_start();
        send_byte(8'h82, 1'b1, "R1", 1'b0);
        send_byte(8'h02, 1'b1, "R4", 1'b0);
        send_byte(8'h06, 1'b1, "R9", 1'b0);
        send_byte(8'h03, 1'b1, "R4", 1'b0);
        bus_stop();
        expect_state(4'd3, 1'b0, 4'd7, 1'b1, 6'b010000, "R9");

        // R2: wrong address, following bytes ignored
        bus_start();
        send_byte(8'h84, 1'b0, "R2", 1'b0);
        send_byte(8'h00, 1'b0, "R2", 1'b0);
        send_byte(8'h00, 1'b0, "R2", 1'b0);
        bus_stop();
        expect_state(4'd3, 1'b0, 4'd7, 1'b1, 6'b010000, "R2");

        // R3: read header refused
        bus_start();
        send_byte(8'h83, 1'b0, "R3", 1'b0);
        send_byte(8'h00, 1'b0, "R3", 1'b0);
        bus_stop();
        expect_state(4'd3, 1'b0, 4'd7, 1'b1, 6'b010000, "R3");

        // R10: repeated START keeps the stored values and restarts addressing
        bus_start();
        send_byte(8'h82, 1'b1, "R1", 1'b0);
        send_byte(8'h01, 1'b1, "R4", 1'b0);
        send_byte(8'h08, 1'b1, "R5", 1'b0);
        bus_rstart();
        send_byte(8'h82, 1'b1, "R10", 1'b0);
        send_byte(8'h02, 1'b1, "R10", 1'b0);
        send_byte(8'h00, 1'b1, "R8", 1'b0);
        bus_stop();
        expect_state(4'd3, 1'b0, 4'd8, 1'b0, 6'b000001, "R10");

        // R13: out-of-range pointer, data acknowledged but dropped
        bus_start();
        send_byte(8'h82, 1'b1, "R1", 1'b0);
        send_byte(8'h05, 1'b1, "R13", 1'b0);
        send_byte(8'h00, 1'b1, "R13", 1'b0);
        send_byte(8'h02, 1'b1, "R13", 1'b0);
        bus_stop();
        expect_state(4'd3, 1'b0, 4'd8, 1'b0, 6'b000001, "R13");

        // R11: short spikes on both lines inside a data byte have no effect
        bus_start();
        send_byte(8'h82, 1'b1, "R1", 1'b0);
        send_byte(8'h00, 1'b1, "R4", 1'b0);
        send_byte(8'h06, 1'b1, "R11", 1'b1);
        send_byte(8'h04, 1'b1, "R11", 1'b1);
        bus_stop();
        expect_state(4'd6, 1'b0, 4'd4, 1'b0, 6'b000001, "R11");

        wt(5);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wt(150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run still busy, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule